// File: doc/BRIEF.md
# Serial Input Frame Builder for a Codec Audio Link

This block sits on the codec side of a time-slotted serial audio link. Each frame it gathers a set of parallel inputs and sends them out one bit at a time as a single 256-bit frame. The inputs are a codec-ready flag, twelve per-slot valid tags, a status register index, slot-request bits, a status data word and ten 20-bit sample words. The controller on the far side reads the frame on the falling edges of the bit clock.

A frame starts when a low-to-high change of `sync` is seen on a falling bit-clock edge. On the next rising edge the block captures every parallel input and drives the first bit. It then drives one bit, MSB first, on each later rising edge. Slot 0 holds the tag word and is 16 bits wide. Slots 1 to 12 are 20 bits each. Any field that is tagged invalid, reserved or unassigned goes out as zeros. While the ready flag is low the whole frame is zero.

Top module: `aclink_in_framer`

## Requirements
- R1: `sync` is sampled on falling edges of `bit_clk`. A falling edge that sees it high, when the previous falling edge saw it low, marks a frame start.
- R2: Frame bit 255 goes out on the first rising edge after the start edge. Bits 254 down to 0 follow, one per rising edge. After bit 0, `sdata` stays 0 until the next frame.
- R3: The first frame bit (slot 0 bit 15) equals `codec_ready`.
- R4: Slot 0 bits 14 to 3 carry the tags of slots 1 to 12 in order, with `slot_valid[11]` tagging slot 1 and `slot_valid[0]` tagging slot 12. Slot 0 bits 2 to 0 are 0.
- R5: When `codec_ready` is 0 at capture, every bit of the frame is 0, whatever the tags say.
- R6: A slot whose tag is 0 is sent as 20 zeros.
- R7: Slot 1 is laid out as follows: bit 19 is 0, bits 18:12 are `status_index`, bits 11:2 are `slot_req`, and bits 1:0 are 0.
- R8: Slot 2 is laid out as follows: bits 19:4 are `status_data`, and bits 3:0 are 0.
- R9: Slots 3 to 12 carry the ten sample words MSB first. `sample_words[199:180]` feeds slot 3, and so on down to `sample_words[19:0]`, which feeds slot 12.
- R10: All inputs are captured on the rising edge that drives the first bit. Later changes have no effect on the frame in flight.
- R11: A new `sync` start during a frame abandons it. The new frame begins from bit 255.
- R12: While `rst_n` is low, and after its release until the first start, `sdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync | input | 1 | Frame marker driven by the controller |
| codec_ready | input | 1 | Codec ready flag |
| slot_valid | input | 12 | Valid tags, bit 11 for slot 1 through bit 0 for slot 12 |
| status_index | input | 7 | Register index echoed in slot 1 |
| slot_req | input | 10 | Slot-request bits in slot 1 |
| status_data | input | 16 | Register contents for slot 2 |
| sample_words | input | 200 | Ten 20-bit sample words, slot 3 in the top bits |
| sdata | output | 1 | Serial frame output |

## Verification
Two situations are hard to reach from the ports. The first is a `sync` rise arriving in the middle of a frame. The second is an input change between the capture edge and the end of the frame. The stimulus lowers and raises `sync` again about a hundred bits into a frame, and in another frame it rewrites every field halfway through. A bit-level model in the bench then confirms two things: the new frame restarts from its first bit, and the old frame keeps the values it captured.

// File: rtl/aclink_in_framer.sv
module aclink_in_framer #(
  parameter int SLOTS  = 12,
  parameter int SLOT_W = 20,
  parameter int TAG_W  = 16,
  parameter int IDX_W  = 7,
  parameter int REQ_W  = 10,
  parameter int STAT_W = 16
) (
  input  logic                             bit_clk,
  input  logic                             rst_n,
  input  logic                             sync,
  input  logic                             codec_ready,
  input  logic [SLOTS-1:0]                 slot_valid,
  input  logic [IDX_W-1:0]                 status_index,
  input  logic [REQ_W-1:0]                 slot_req,
  input  logic [STAT_W-1:0]                status_data,
  input  logic [(SLOTS-2)*SLOT_W-1:0]      sample_words,
  output logic                             sdata
);
  localparam int FRAME_W = TAG_W + SLOTS * SLOT_W;
  localparam int PAD0_W  = TAG_W - 1 - SLOTS;
  localparam int PAD2_W  = SLOT_W - STAT_W;

  logic               sync_q, start;
  logic [SLOTS-1:0]   tag_eff;
  logic [SLOTS*SLOT_W-1:0] slot_bits;
  logic [FRAME_W-1:0] frame_next, shreg;

  assign tag_eff = codec_ready ? slot_valid : '0;

  for (genvar s = 1; s <= SLOTS; s++) begin : g_slot
    logic [SLOT_W-1:0] raw;
    if (s == 1) begin : g_stat_addr
      assign raw = {1'b0, status_index, slot_req, 2'b00};
    end else if (s == 2) begin : g_stat_data
      assign raw = {status_data, {PAD2_W{1'b0}}};
    end else begin : g_sample
      assign raw = sample_words[SLOT_W*(SLOTS-s+1)-1 -: SLOT_W];
    end
    assign slot_bits[SLOT_W*(SLOTS-s+1)-1 -: SLOT_W] = tag_eff[SLOTS-s] ? raw : '0;
  end

  assign frame_next = {codec_ready, tag_eff, {PAD0_W{1'b0}}, slot_bits};

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      start  <= 1'b0;
    end else begin
      sync_q <= sync;
      start  <= sync & ~sync_q;
    end
  end

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n)     shreg <= '0;
    else if (start) shreg <= frame_next;
    else            shreg <= shreg << 1;
  end

  assign sdata = shreg[FRAME_W-1];
endmodule

module aclink_in_framer_chk #(
  parameter int FRAME_W = 256
) (
  input logic bit_clk,
  input logic rst_n,
  input logic sync,
  input logic codec_ready,
  input logic sdata
);
  localparam int CW = $clog2(FRAME_W + 1);
  localparam logic [CW-1:0] IDLE = CW'(FRAME_W);

  logic          s_prev, s_start, rdy_cap;
  logic [CW-1:0] cnt;

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      s_prev  <= 1'b0;
      s_start <= 1'b0;
    end else begin
      s_prev  <= sync;
      s_start <= sync && !s_prev;
    end
  end

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= IDLE;
      rdy_cap <= 1'b0;
    end else if (s_start) begin
      cnt     <= '0;
      rdy_cap <= codec_ready;
    end else if (cnt != IDLE) begin
      cnt     <= cnt + 1'b1;
    end
  end

  p_ready_bit_r3: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (cnt == 0) |-> (sdata == rdy_cap));
  p_not_ready_r5: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (!rdy_cap && cnt != IDLE) |-> !sdata);
  p_idle_low_r2: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (cnt == IDLE) |-> !sdata);
  p_slot0_pad_r4: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (cnt >= 13 && cnt <= 15) |-> !sdata);
  p_slot1_rsv_r7: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (cnt == 16 || cnt == 34 || cnt == 35) |-> !sdata);
  p_slot2_pad_r8: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (cnt >= 52 && cnt <= 55) |-> !sdata);
endmodule

bind aclink_in_framer aclink_in_framer_chk #(.FRAME_W(FRAME_W)) u_chk (
  .bit_clk(bit_clk), .rst_n(rst_n), .sync(sync),
  .codec_ready(codec_ready), .sdata(sdata)
);

// File: tb/aclink_in_framer_test.sv
module aclink_in_framer_test;
  localparam int CLK_PERIOD = 10;

  logic         bit_clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sync = 1'b0;
  logic         codec_ready = 1'b0;
  logic [11:0]  slot_valid = '0;
  logic [6:0]   status_index = '0;
  logic [9:0]   slot_req = '0;
  logic [15:0]  status_data = '0;
  logic [199:0] sample_words = '0;
  logic         sdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  aclink_in_framer uut (
    .bit_clk(bit_clk), .rst_n(rst_n), .sync(sync), .codec_ready(codec_ready),
    .slot_valid(slot_valid), .status_index(status_index), .slot_req(slot_req),
    .status_data(status_data), .sample_words(sample_words), .sdata(sdata)
  );

  always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

  function automatic logic [255:0] build();
    logic [255:0] f = '0;
    logic [19:0]  w;
    if (!codec_ready) return f;        // R5
    f[255] = 1'b1;                     // R3
    for (int s = 1; s <= 12; s++) begin
      f[255 - s] = slot_valid[12 - s]; // R4
      if (!slot_valid[12 - s]) continue; // R6
      if (s == 1)      w = {1'b0, status_index, slot_req, 2'b00};  // R7
      else if (s == 2) w = {status_data, 4'b0000};                  // R8
      else             w = sample_words[199 - 20*(s-3) -: 20];      // R9
      for (int b = 0; b < 20; b++) f[239 - 20*(s-1) - b] = w[19 - b];
    end
    return f;
  endfunction

  function automatic string req_for(int p);
    int i = 255 - p;
    if (p < 0)   return "R2";
    if (i == 0)  return "R3";
    if (i < 16)  return "R4";
    if (i < 36)  return "R7";
    if (i < 56)  return "R8";
    return "R9";
  endfunction

  logic [255:0] exp_frame = '0;
  int  pos = -1;
  bit  pend = 1'b0;
  bit  sprev = 1'b0;
  logic exp_bit;

  // Behavioural model: R1 start detect on falling edges, R2 output per rising edge
  always @(bit_clk) begin
    if (bit_clk) begin
      if (!rst_n) begin
        pos = -1; pend = 1'b0;
      end else if (pend) begin
        exp_frame = build();           // R10 capture at load edge
        pos = 255; pend = 1'b0;        // R11 restart always from bit 255
      end else if (pos >= 0) begin
        pos--;
      end
    end else begin
      exp_bit = (pos >= 0) ? exp_frame[pos] : 1'b0;
      checks++;
      if (!rst_n) begin
        if (sdata !== 1'b0) begin
          errors++;
          $display("FAIL R12: sdata=%b expected 0 in reset", sdata);
        end
        sprev = 1'b0; pend = 1'b0;
      end else begin
        if (sdata !== exp_bit) begin
          errors++;
          $display("FAIL %s: bit pos %0d sdata=%b expected %b", req_for(pos), pos, sdata, exp_bit);
        end
        if (sync && !sprev) pend = 1'b1;  // R1
        sprev = sync;
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge bit_clk);
    #1;
  endtask

  task automatic load_fields(bit rdy, logic [11:0] tags);
    codec_ready  = rdy;
    slot_valid   = tags;
    status_index = 7'($urandom);
    slot_req     = 10'($urandom);
    status_data  = 16'($urandom);
    for (int k = 0; k < 200; k += 20) sample_words[k +: 20] = 20'($urandom);
  endtask

  task automatic pulse_sync();
    sync = 1'b1;
    tick(16);
    sync = 1'b0;
  endtask

  initial begin
    // R12: reset and idle before any sync
    tick(5);
    rst_n = 1'b1;
    tick(20);

    // Full frame, all tags valid (R3 R4 R7 R8 R9)
    load_fields(1'b1, 12'hFFF);
    pulse_sync();
    tick(260);

    // Mixed tags (R6), then idle tail (R2)
    load_fields(1'b1, 12'b1010_0110_1001);
    pulse_sync();
    tick(270);

    // Ready low with tags set (R5)
    load_fields(1'b0, 12'hFFF);
    pulse_sync();
    tick(260);

    // Only slot 1 and 2 tagged, fields all ones
    codec_ready = 1'b1; slot_valid = 12'hC00;
    status_index = '1; slot_req = '1; status_data = '1; sample_words = '1;
    pulse_sync();
    tick(260);

    // R10: change every field mid-frame
    load_fields(1'b1, 12'h5A5);
    pulse_sync();
    tick(100);
    load_fields(1'b0, 12'h0F0);
    tick(160);

    // R11: restart mid-frame with new fields
    load_fields(1'b1, 12'hFFF);
    pulse_sync();
    tick(90);
    load_fields(1'b1, 12'h3C7);
    pulse_sync();
    tick(270);

    // Back-to-back frames with sync held 1 bit
    for (int r = 0; r < 4; r++) begin
      load_fields(1'b1, 12'($urandom));
      sync = 1'b1; tick(1); sync = 1'b0;
      tick(255);
    end
    tick(10);

    // R12: reset in the middle of a frame
    load_fields(1'b1, 12'hFFF);
    pulse_sync();
    tick(40);
    rst_n = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(30);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule